// File: doc/BRIEF.md
# Byte-Sequence Power State Sequencer

This block steps one processor core into and out of a low-power state. Software fills a small byte memory with command sequences, one sequence per low-power mode. It then writes the first index of the chosen sequence and an enable bit into a control word. When the core reports that it has executed a wait-for-interrupt instruction, the sequencer runs the stored bytes in order from that index. Each byte is decoded as one of four commands: drive a new pattern onto the power-control outputs (clamp, clock gate, retention and so on), wait a number of cycles, stall for a wake interrupt, or finish.

The stall command splits a sequence into a power-down half and a power-up half. A wake interrupt that arrives while the sequence is still running ahead of the stall is remembered, so the stall then passes at once. The finish command puts the outputs back to the run pattern and returns the machine to idle. A busy flag covers the whole run and can be read back through the register port.

Top module: `pseq_top`

## Requirements
- R1: After reset, `pwr_ctl` is 0 (the run pattern), `busy` is 0, and the control word reads back as 0.
- R2: When control bit 0 (enable) is 1 and `wfi_req` is sampled high while idle, `busy` rises on the next cycle and execution begins at the index held in control bits [13:8].
- R3: When enable is 0, `wfi_req` is ignored: `busy` stays 0 and `pwr_ctl` stays 0.
- R4: A byte with bit 7 = 0 is a set command. It drives `pwr_ctl` to the byte's bits [6:0]. Exactly one command executes per cycle.
- R5: A byte from 0x81 to 0xFE is a delay command. After the cycle it executes, it holds `pwr_ctl` for N further cycles, where N is bits [6:0], before the next byte executes.
- R6: Byte 0x80 is a wait command. If no wake is pending, the sequencer stalls with `pwr_ctl` unchanged until `wake_irq` is sampled high. It then continues with the next byte.
- R7: A `wake_irq` pulse sampled while busy and before the wait command is latched, so the wait then completes without stalling. A pulse sampled while idle is not latched.
- R8: Byte 0xFF is the end command. On the cycle after it executes, `pwr_ctl` is 0 and `busy` is 0.
- R9: The register port maps addresses 0x00–0x3F to the sequence bytes, 0x40 to the control word and 0x41 to status, with busy in bit 0. All three can be read back on `reg_rdata` combinationally.
- R10: The sequence index wraps from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register/memory write strobe |
| reg_addr | input | 7 | Register/memory address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| wfi_req | input | 1 | Core has executed wait-for-interrupt |
| wake_irq | input | 1 | Wake interrupt |
| pwr_ctl | output | 7 | Power-control output pattern |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the block with its default parameters:
- a 6-bit index, giving 64 sequence bytes;
- 8-bit commands, giving a 7-bit output pattern and a 7-bit delay count;
- a 16-bit data word;
- reset memory entries.

With a 64-entry space, a sequence placed at the last byte can run through the index wrap into the bytes at address 0. The 7-bit count field lets both a one-cycle delay and a multi-cycle delay be timed exactly against the busy window. Each wake is placed at a chosen cycle relative to the wait command: ahead of it, at it, or after it. The bench can therefore tell latched wakes, direct wakes and stalls apart by the total busy length.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EXEC,
      ST_DELAY,
      ST_WAIT
   } seq_state_t;

   typedef enum logic [1:0] {
      OP_SET,
      OP_WAIT,
      OP_DELAY,
      OP_END
   } seq_op_t;

endpackage

// File: rtl/pseq_decode.sv
module pseq_decode
   import pseq_pkg::*;
#(
   parameter int CMD_W = 8,
   localparam int ARG_W = CMD_W - 1
) (
   input  logic [CMD_W-1:0] cmd,
   output seq_op_t          op,
   output logic [ARG_W-1:0] arg
);

   if (CMD_W < 3) begin : g_bad_cmd_w
      $error("pseq_decode: CMD_W must be at least 3");
   end

   assign arg = cmd[ARG_W-1:0];

   always_comb begin
      if (!cmd[CMD_W-1])
         op = OP_SET;
      else if (arg == '0)
         op = OP_WAIT;
      else if (&arg)
         op = OP_END;
      else
         op = OP_DELAY;
   end

endmodule

// File: rtl/pseq_mem.sv
module pseq_mem #(
   parameter int IDX_W     = 6,
   parameter int CMD_W     = 8,
   parameter bit MEM_RESET = 1'b1,
   localparam int DEPTH    = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic [CMD_W-1:0] wdata,
   input  logic [IDX_W-1:0] raddr_a,
   output logic [CMD_W-1:0] rdata_a,
   input  logic [IDX_W-1:0] raddr_b,
   output logic [CMD_W-1:0] rdata_b
);

   localparam logic [CMD_W-1:0] END_CODE = '1;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx_w
      $error("pseq_mem: IDX_W out of range 1..10");
   end

   logic [CMD_W-1:0] store [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      logic hit;
      assign hit = we && (waddr == IDX_W'(i));
      if (MEM_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               store[i] <= END_CODE;
            else if (hit)
               store[i] <= wdata;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit)
               store[i] <= wdata;
         end
      end
   end

   assign rdata_a = store[raddr_a];
   assign rdata_b = store[raddr_b];

endmodule

// File: rtl/pseq_regs.sv
module pseq_regs #(
   parameter int IDX_W    = 6,
   parameter int CMD_W    = 8,
   parameter int DATA_W   = 16,
   localparam int ADDR_W  = IDX_W + 1,
   localparam int START_LSB = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              busy,
   input  logic [CMD_W-1:0]  mem_rdata,
   output logic              mem_we,
   output logic [IDX_W-1:0]  mem_addr,
   output logic [CMD_W-1:0]  mem_wdata,
   output logic              seq_en,
   output logic [IDX_W-1:0]  start_idx
);

   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(1 << IDX_W);
   localparam logic [ADDR_W-1:0] STAT_ADDR = CTRL_ADDR + ADDR_W'(1);

   if (DATA_W < START_LSB + IDX_W || DATA_W < CMD_W) begin : g_bad_data_w
      $error("pseq_regs: DATA_W too narrow for control word or command byte");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic              is_mem;

   assign is_mem    = !reg_addr[ADDR_W-1];
   assign mem_addr  = reg_addr[IDX_W-1:0];
   assign mem_we    = reg_wr && is_mem;
   assign mem_wdata = reg_wdata[CMD_W-1:0];
   assign seq_en    = ctrl_q[0];
   assign start_idx = ctrl_q[START_LSB +: IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (reg_wr && reg_addr == CTRL_ADDR)
         ctrl_q <= reg_wdata;
   end

   always_comb begin
      reg_rdata = '0;
      if (is_mem)
         reg_rdata = DATA_W'(mem_rdata);
      else if (reg_addr == CTRL_ADDR)
         reg_rdata = ctrl_q;
      else if (reg_addr == STAT_ADDR)
         reg_rdata = DATA_W'(busy);
   end

   p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == CTRL_ADDR) |=> (ctrl_q == $past(reg_wdata)));

endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
   import pseq_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int CMD_W  = 8,
   localparam int ARG_W = CMD_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seq_en,
   input  logic [IDX_W-1:0] start_idx,
   input  logic             wfi_req,
   input  logic             wake_irq,
   input  seq_op_t          op,
   input  logic [ARG_W-1:0] arg,
   output logic [IDX_W-1:0] pc,
   output logic [ARG_W-1:0] pwr_ctl,
   output logic             busy
);

   localparam logic [ARG_W-1:0] RUN_PATTERN = '0;

   seq_state_t       state;
   logic [ARG_W-1:0] dly_cnt;
   logic             wake_pend;

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pc        <= '0;
         pwr_ctl   <= RUN_PATTERN;
         dly_cnt   <= '0;
         wake_pend <= 1'b0;
      end else begin
         if (state != ST_IDLE && wake_irq)
            wake_pend <= 1'b1;
         unique case (state)
            ST_IDLE: begin
               wake_pend <= 1'b0;
               if (wfi_req && seq_en) begin
                  state <= ST_EXEC;
                  pc    <= start_idx;
               end
            end
            ST_EXEC: begin
               unique case (op)
                  OP_SET: begin
                     pwr_ctl <= arg;
                     pc      <= pc + 1'b1;
                  end
                  OP_WAIT: begin
                     if (wake_pend || wake_irq) begin
                        pc        <= pc + 1'b1;
                        wake_pend <= 1'b0;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
                  OP_DELAY: begin
                     dly_cnt <= arg;
                     state   <= ST_DELAY;
                  end
                  OP_END: begin
                     pwr_ctl   <= RUN_PATTERN;
                     wake_pend <= 1'b0;
                     state     <= ST_IDLE;
                  end
               endcase
            end
            ST_DELAY: begin
               if (dly_cnt == ARG_W'(1)) begin
                  pc    <= pc + 1'b1;
                  state <= ST_EXEC;
               end else begin
                  dly_cnt <= dly_cnt - 1'b1;
               end
            end
            ST_WAIT: begin
               if (wake_irq) begin
                  pc        <= pc + 1'b1;
                  wake_pend <= 1'b0;
                  state     <= ST_EXEC;
               end
            end
         endcase
      end
   end

   // R2: an enabled request starts at the programmed index
   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && wfi_req && seq_en) |=> (busy && pc == $past(start_idx)));

   // R3: a request with enable clear leaves the machine idle
   p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !(wfi_req && seq_en)) |=> (state == ST_IDLE));

   // R5: outputs are held through a delay
   p_delay_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DELAY) |=> $stable(pwr_ctl));

   // R6: a stall without wake keeps outputs and state
   p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !wake_irq) |=> (state == ST_WAIT && $stable(pwr_ctl)));

   // R7: a pending wake lets the wait command pass at once
   p_latched_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && op == OP_WAIT && wake_pend)
      |=> (state == ST_EXEC && pc == $past(pc) + IDX_W'(1)));

   // R7: nothing is remembered while idle
   p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> (state != ST_IDLE || !wake_pend));

   // R8: the end command returns to run pattern and idle
   p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && op == OP_END) |=> (!busy && pwr_ctl == RUN_PATTERN));

endmodule

// File: rtl/pseq_top.sv
module pseq_top
   import pseq_pkg::*;
#(
   parameter int IDX_W     = 6,
   parameter int CMD_W     = 8,
   parameter int DATA_W    = 16,
   parameter bit MEM_RESET = 1'b1,
   localparam int ADDR_W   = IDX_W + 1,
   localparam int OUT_W    = CMD_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              wfi_req,
   input  logic              wake_irq,
   output logic [OUT_W-1:0]  pwr_ctl,
   output logic              busy
);

   logic             mem_we;
   logic [IDX_W-1:0] mem_addr;
   logic [CMD_W-1:0] mem_wdata;
   logic [CMD_W-1:0] mem_rdata;
   logic [CMD_W-1:0] cmd_byte;
   logic [IDX_W-1:0] pc;
   logic             seq_en;
   logic [IDX_W-1:0] start_idx;
   seq_op_t          op;
   logic [OUT_W-1:0] arg;

   pseq_regs #(
      .IDX_W (IDX_W),
      .CMD_W (CMD_W),
      .DATA_W(DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .busy     (busy),
      .mem_rdata(mem_rdata),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .seq_en   (seq_en),
      .start_idx(start_idx)
   );

   pseq_mem #(
      .IDX_W    (IDX_W),
      .CMD_W    (CMD_W),
      .MEM_RESET(MEM_RESET)
   ) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (mem_we),
      .waddr  (mem_addr),
      .wdata  (mem_wdata),
      .raddr_a(pc),
      .rdata_a(cmd_byte),
      .raddr_b(mem_addr),
      .rdata_b(mem_rdata)
   );

   pseq_decode #(
      .CMD_W(CMD_W)
   ) u_dec (
      .cmd(cmd_byte),
      .op (op),
      .arg(arg)
   );

   pseq_fsm #(
      .IDX_W(IDX_W),
      .CMD_W(CMD_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .seq_en   (seq_en),
      .start_idx(start_idx),
      .wfi_req  (wfi_req),
      .wake_irq (wake_irq),
      .op       (op),
      .arg      (arg),
      .pc       (pc),
      .pwr_ctl  (pwr_ctl),
      .busy     (busy)
   );

   // R1: idle always presents the run pattern
   p_idle_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pwr_ctl == '0));

endmodule

// File: tb/sim_pseq_top.sv
`timescale 1ns/1ps
module sim_pseq_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        wfi_req = 1'b0;
   logic        wake_irq = 1'b0;
   logic [6:0]  pwr_ctl;
   logic        busy;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pseq_top u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .wfi_req  (wfi_req),
      .wake_irq (wake_irq),
      .pwr_ctl  (pwr_ctl),
      .busy     (busy)
   );

   // {start, wake cycle (0 = none), sample cycle, expected pwr_ctl, expected busy cycles}
   localparam logic [39:0] VEC [7] = '{
      {8'd0,  8'd1,  8'd1,  8'h00, 8'd5},   // R7 early wake latched
      {8'd0,  8'd8,  8'd8,  8'h03, 8'd10},  // R6 stall then wake
      {8'd8,  8'd5,  8'd5,  8'h05, 8'd12},  // R5 wake during delay
      {8'd8,  8'd20, 8'd20, 8'h0F, 8'd23},  // R5 R6 long stall
      {8'd16, 8'd0,  8'd2,  8'h02, 8'd2},   // R4 set then end
      {8'd24, 8'd0,  8'd4,  8'h09, 8'd4},   // R5 one-cycle delay
      {8'd63, 8'd10, 8'd2,  8'h21, 8'd12}   // R10 index wrap
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic run(input int idx, input int wk, input int sk, input int es,
                      input int eb, input string tag);
      int k;
      wr(7'h40, 16'((idx << 8) | 1));
      wfi_req = 1'b1;
      @(negedge clk);
      wfi_req = 1'b0;
      k = 1;
      while (busy && k < 500) begin
         if (k == sk) chk(pwr_ctl == 7'(es), {tag, " R4 pattern"}, pwr_ctl, es);
         wake_irq = (k == wk);
         @(negedge clk);
         k++;
      end
      wake_irq = 1'b0;
      chk((k - 1) == eb, {tag, " R2 busy length"}, k - 1, eb);
      chk(pwr_ctl == 7'h00, {tag, " R8 run pattern after end"}, pwr_ctl, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(pwr_ctl == 7'h00, "R1 pwr_ctl at reset", pwr_ctl, 0);
      chk(busy == 1'b0, "R1 busy at reset", busy, 0);
      reg_addr = 7'h40; #1;
      chk(reg_rdata == 16'h0000, "R1 control at reset", reg_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // program sequences
      wr(7'd0, 16'h01); wr(7'd1, 16'h03); wr(7'd2, 16'h80); wr(7'd3, 16'h01); wr(7'd4, 16'hFF);
      wr(7'd8, 16'h05); wr(7'd9, 16'h85); wr(7'd10, 16'h0F); wr(7'd11, 16'h80);
      wr(7'd12, 16'h07); wr(7'd13, 16'h00); wr(7'd14, 16'hFF);
      wr(7'd16, 16'h02); wr(7'd17, 16'hFF);
      wr(7'd24, 16'h81); wr(7'd25, 16'h09); wr(7'd26, 16'hFF);
      wr(7'd63, 16'h21);

      reg_addr = 7'd9; #1;
      chk(reg_rdata == 16'h0085, "R9 memory readback", reg_rdata, 16'h85);
      wr(7'h40, 16'h0A01);
      reg_addr = 7'h40; #1;
      chk(reg_rdata == 16'h0A01, "R9 control readback", reg_rdata, 16'h0A01);

      // R3: disabled request ignored
      wr(7'h40, 16'h0000);
      wfi_req = 1'b1;
      @(negedge clk);
      wfi_req = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk(busy == 1'b0, "R3 busy stays low", busy, 0);
         chk(pwr_ctl == 7'h00, "R3 outputs stay run", pwr_ctl, 0);
         @(negedge clk);
      end

      // table walk
      for (int v = 0; v < 7; v++) begin
         run(int'(VEC[v][39:32]), int'(VEC[v][31:24]), int'(VEC[v][23:16]),
             int'(VEC[v][15:8]), int'(VEC[v][7:0]), $sformatf("vec%0d", v));
         @(negedge clk);
      end

      // R7: wake while idle not latched; stall must still occur
      wake_irq = 1'b1;
      @(negedge clk);
      wake_irq = 1'b0;
      @(negedge clk);
      run(0, 8, 8, 3, 10, "R7 idle wake");

      // R9 R6: status during a stall
      wr(7'h40, 16'h0001);
      wfi_req = 1'b1;
      @(negedge clk);
      wfi_req = 1'b0;
      repeat (6) @(negedge clk);
      reg_addr = 7'h41; #1;
      chk(reg_rdata == 16'h0001, "R9 status busy", reg_rdata, 1);
      chk(pwr_ctl == 7'h03, "R6 stalled pattern", pwr_ctl, 3);
      wake_irq = 1'b1;
      @(negedge clk);
      wake_irq = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(reg_rdata == 16'h0000, "R9 status idle", reg_rdata, 0);
      chk(busy == 1'b0, "R8 busy after end", busy, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule